// File: doc/BRIEF.md
# Polled Input/Output Port Register Block

This block is a small peripheral that sits on a simple word-addressed processor bus. Software talks to it through six word slots starting at 0xFF00 and spaced two apart: three data slots followed by three control slots. One receive channel takes words from a device-side valid strobe. One transmit channel hands a word to a slow sink that acknowledges completion after a fixed latency.

The two channels use different handshakes. On receive, a ready flag rises when a word is captured. That flag drives the interrupt request. Software reads the word, then writes the ready bit back to zero, and only then can a new word or a new request arrive. On transmit, software loads the data slot and sets a start bit. The sink model pulses its acknowledge after a parameterised delay, and a separate completion bit then stays set until software clears the control slot.

The bus read has one cycle of latency. Reset is synchronous and active low.

Top module: `pio_port_block`

## Requirements
- R1: While rst_n is low at a clock edge, every slot reads back zero afterwards, irq is 0 and out_strobe is 0.
- R2: bus_rdata shows the addressed slot one cycle after a bus_re cycle, and is zero otherwise. Slot map:
  - 0xFF00: received word.
  - 0xFF02: transmit word.
  - 0xFF06: receive control (bit 0 ready, bit 2 overrun).
  - 0xFF08: transmit control (bit 0 start, bit 1 done).
  - 0xFF04, 0xFF0A, odd addresses and every other address read zero, and writes to them have no effect.
- R3: An in_valid pulse while the ready bit is 0 stores in_data in slot 0xFF00 and sets bit 0 of 0xFF06.
- R4: An in_valid pulse while the ready bit is 1 (and no clearing write in that cycle) is dropped. The held word is kept and overrun (bit 2 of 0xFF06) is set.
- R5: A write to 0xFF06 with wdata bit 0 equal to 0 clears both ready and overrun. A write there with bit 0 equal to 1 changes nothing, and writes to 0xFF00 are ignored.
- R6: When a clearing write to 0xFF06 and an in_valid pulse fall in the same cycle, the new word is accepted: ready stays 1 and overrun is 0.
- R7: irq goes to 1 in the cycle after a word is accepted. It then stays 1 until the clearing write, so no new request can start before that write.
- R8: A write to 0xFF08 with bit 0 equal to 1 while no transfer is in progress sets the start bit. It also gives exactly one out_strobe cycle, with out_data equal to slot 0xFF02.
- R9: The done bit (bit 1 of 0xFF08) reads 0 just after start and becomes 1 within SINK_LAT+3 cycles.
- R10: A start write while a transfer is in progress produces no further out_strobe.
- R11: A write to 0xFF08 with bit 0 equal to 0 clears both the start bit and the done bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | DATA_W | Read data, one cycle after bus_re |
| in_valid | input | 1 | Receive word strobe |
| in_data | input | DATA_W | Receive word |
| out_strobe | output | 1 | One-cycle transmit start strobe |
| out_data | output | DATA_W | Transmit word |
| irq | output | 1 | Interrupt request level |

## Verification
The receive path is driven with four patterns, and each one separates a different flag rule:
- a lone word, which shows capture and the rise of irq;
- a second word while ready is still set, which shows the word is dropped and overrun is set;
- a clearing write alone, which shows both flags are cleared;
- a clearing write in the same cycle as a new word, which shows that the clear and the capture are ordered correctly.

The transmit path is tested with a plain start and a repeated start during the sink delay, and the test counts the strobes. A clear of the transmit control slot is then checked to drop both bits. Reads of the reserved slots, odd addresses and addresses below the base show that the decoder matches neither partial nor aliased addresses.

// File: rtl/pio_pkg.sv
// Shared slot indices and control-bit positions for the polled port block.
package pio_pkg;
    localparam int NUM_SLOTS = 6;
    localparam int SLOT_DIN  = 0;   // received word
    localparam int SLOT_DOUT = 1;   // transmit word
    localparam int SLOT_DRSV = 2;   // reserved data slot, reads zero
    localparam int SLOT_CIN  = 3;   // receive control
    localparam int SLOT_COUT = 4;   // transmit control
    localparam int SLOT_CRSV = 5;   // reserved control slot, reads zero
    localparam int RDY_BIT = 0;
    localparam int OVR_BIT = 2;
    localparam int GO_BIT  = 0;
    localparam int FIN_BIT = 1;
endpackage

// File: rtl/pio_addr_decode.sv
// Address decoder: turns a bus word address into a one-hot slot select.
// Assumes slots sit at BASE + 2*i; odd or out-of-range addresses select nothing.
module pio_addr_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hFF00
) (
    input  logic [ADDR_W-1:0]              addr,
    output logic [pio_pkg::NUM_SLOTS-1:0]  sel
);
    logic [ADDR_W-1:0] offs;

    // Offset from the base; addresses below the base wrap to a large value.
    always_comb offs = addr - BASE;

    for (genvar i = 0; i < pio_pkg::NUM_SLOTS; i++) begin : g_slot
        assign sel[i] = (offs == ADDR_W'(2 * i));
    end
endmodule

// File: rtl/pio_in_chan.sv
// Receive channel: captures a device word when the ready flag is free and
// flags overrun when a word arrives while it is still held.
// Assumes clr_wr is a decoded clearing write to the receive control slot.
module pio_in_chan #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              clr_wr,
    output logic [DATA_W-1:0] data_q,
    output logic              ready_q,
    output logic              ovr_q
);
    logic accept;

    // A word is taken when the slot is free or is being freed this cycle.
    always_comb accept = in_valid && (!ready_q || clr_wr);

    // Data capture and flag set/clear rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (accept) data_q <= in_data;
            if (accept)      ready_q <= 1'b1;
            else if (clr_wr) ready_q <= 1'b0;
            if (clr_wr)                    ovr_q <= 1'b0;
            else if (in_valid && ready_q)  ovr_q <= 1'b1;
        end
    end

    // R4
    overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> ready_q);
    // R4
    held_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && !clr_wr) |=> $stable(data_q));
    // R7
    ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(in_valid));
endmodule

// File: rtl/pio_sink_model.sv
// Slow sink model: after a start strobe, counts LAT cycles and then
// returns a one-cycle completion pulse. Assumes no start while counting.
module pio_sink_model #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done_q
);
    localparam int CNT_W = $clog2(LAT + 1);
    logic [CNT_W-1:0] cnt;

    // Latency counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            if (start)            cnt <= CNT_W'(LAT);
            else if (cnt != '0)   cnt <= cnt - 1'b1;
            done_q <= (cnt == CNT_W'(1));
        end
    end

    // R9
    sink_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(LAT));
    // R9
    sink_done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/pio_out_chan.sv
// Transmit channel: start/done control bits, busy tracking and the start strobe.
// Assumes go_wr and clr_wr are decoded writes to the transmit control slot.
module pio_out_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic go_wr,
    input  logic clr_wr,
    input  logic sink_done,
    output logic go_q,
    output logic fin_q,
    output logic busy_q,
    output logic strobe_q
);
    logic accept;

    // A start only counts when no transfer is outstanding.
    always_comb accept = go_wr && !busy_q;

    // Control bits, busy state and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q     <= 1'b0;
            fin_q    <= 1'b0;
            busy_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= accept;
            if (accept)         busy_q <= 1'b1;
            else if (sink_done) busy_q <= 1'b0;
            if (accept)      go_q <= 1'b1;
            else if (clr_wr) go_q <= 1'b0;
            if (sink_done)             fin_q <= 1'b1;
            else if (accept || clr_wr) fin_q <= 1'b0;
        end
    end

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q);
    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !strobe_q);
    // R9
    fin_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fin_q) |-> $past(sink_done));
endmodule

// File: rtl/pio_port_block.sv
// Polled I/O port register block: bus slot decode, transmit data register,
// registered read mux, receive/transmit channels and the sink model.
// Assumes single-cycle bus writes and one-cycle read latency.
module pio_port_block #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hFF00,
    parameter int SINK_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_strobe,
    output logic [DATA_W-1:0] out_data,
    output logic              irq
);
    import pio_pkg::*;

    logic [NUM_SLOTS-1:0] sel;
    logic [DATA_W-1:0]    din_q, dout_q, rd_mux;
    logic                 ready_q, ovr_q, go_q, fin_q, busy_q, sink_done;
    logic                 in_clr_wr, out_go_wr, out_clr_wr;

    pio_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr(bus_addr), .sel(sel));

    // Decoded control writes split by the written bit 0.
    always_comb begin
        in_clr_wr  = bus_we && sel[SLOT_CIN]  && !bus_wdata[RDY_BIT];
        out_go_wr  = bus_we && sel[SLOT_COUT] &&  bus_wdata[GO_BIT];
        out_clr_wr = bus_we && sel[SLOT_COUT] && !bus_wdata[GO_BIT];
    end

    pio_in_chan #(.DATA_W(DATA_W)) u_in (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .clr_wr(in_clr_wr), .data_q(din_q), .ready_q(ready_q), .ovr_q(ovr_q));

    pio_out_chan u_out (
        .clk(clk), .rst_n(rst_n), .go_wr(out_go_wr), .clr_wr(out_clr_wr),
        .sink_done(sink_done), .go_q(go_q), .fin_q(fin_q), .busy_q(busy_q),
        .strobe_q(out_strobe));

    pio_sink_model #(.LAT(SINK_LAT)) u_sink (
        .clk(clk), .rst_n(rst_n), .start(out_strobe), .done_q(sink_done));

    // Transmit data register written through its slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dout_q <= '0;
        else if (bus_we && sel[SLOT_DOUT]) dout_q <= bus_wdata;
    end

    // Read mux over the mapped slots; reserved and unmapped read zero.
    always_comb begin
        rd_mux = '0;
        if (sel[SLOT_DIN])  rd_mux = din_q;
        if (sel[SLOT_DOUT]) rd_mux = dout_q;
        if (sel[SLOT_CIN]) begin
            rd_mux[RDY_BIT] = ready_q;
            rd_mux[OVR_BIT] = ovr_q;
        end
        if (sel[SLOT_COUT]) begin
            rd_mux[GO_BIT]  = go_q;
            rd_mux[FIN_BIT] = fin_q;
        end
    end

    // Registered read data, zero when no read was issued.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    assign out_data = dout_q;
    assign irq      = ready_q;

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    // R2
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0));
    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !in_clr_wr) |=> irq);
    // R8
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |-> go_q);
endmodule

// File: tb/pio_port_block_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module pio_port_block_tb;
    localparam int DW = 16;
    localparam int AW = 16;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata, in_data = '0, out_data;
    logic bus_we = 1'b0, bus_re = 1'b0, in_valid = 1'b0, out_strobe, irq;

    int checks = 0, failures = 0, strobes = 0;
    logic [DW-1:0] strobe_word = '0;

    always #5 clk = ~clk;

    pio_port_block #(.DATA_W(DW), .ADDR_W(AW), .SINK_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .in_valid(in_valid), .in_data(in_data), .out_strobe(out_strobe),
        .out_data(out_data), .irq(irq));

    // Strobe monitor, sampling away from the active edge.
    always @(negedge clk) if (out_strobe) begin
        strobes++;
        strobe_word = out_data;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk); bus_addr = a; bus_re = 1'b1;
        @(posedge clk); #1 d = bus_rdata;
        @(negedge clk); bus_re = 1'b0;
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge clk); in_data = d; in_valid = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1;
        chk("R1 irq", irq, 0);
        chk("R1 out_strobe", out_strobe, 0);
        for (int i = 0; i < 6; i++) begin
            rd(16'hFF00 + 16'(2 * i), v);
            chk("R1 slot", v, 0);
        end
    endtask

    task automatic t_map;
        logic [DW-1:0] v;
        wr(16'hFF02, 16'h1234); rd(16'hFF02, v); chk("R2 dout", v, 16'h1234);
        wr(16'hFF04, 16'hBEEF); rd(16'hFF04, v); chk("R2 rsv data", v, 0);
        wr(16'hFF0A, 16'hBEEF); rd(16'hFF0A, v); chk("R2 rsv ctrl", v, 0);
        rd(16'hFF03, v); chk("R2 odd", v, 0);
        rd(16'h0002, v); chk("R2 below base", v, 0);
        rd(16'hFF0C, v); chk("R2 above map", v, 0);
        @(negedge clk); chk("R2 idle rdata", bus_rdata, 0);
    endtask

    task automatic t_input;
        logic [DW-1:0] v;
        @(negedge clk); in_data = 16'hA5C3; in_valid = 1'b1;
        @(posedge clk); #1 chk("R7 irq next cycle", irq, 1);
        @(negedge clk); in_valid = 1'b0;
        rd(16'hFF00, v); chk("R3 word", v, 16'hA5C3);
        rd(16'hFF06, v); chk("R3 ready", v, 16'h0001);
        chk("R7 irq held", irq, 1);
    endtask

    task automatic t_overrun;
        logic [DW-1:0] v;
        push(16'h7777);
        rd(16'hFF00, v); chk("R4 word kept", v, 16'hA5C3);
        rd(16'hFF06, v); chk("R4 overrun", v, 16'h0005);
        chk("R7 irq no new request", irq, 1);
    endtask

    task automatic t_clear;
        logic [DW-1:0] v;
        wr(16'hFF06, 16'h0001); rd(16'hFF06, v); chk("R5 set ignored", v, 16'h0005);
        wr(16'hFF00, 16'h0000); rd(16'hFF00, v); chk("R5 din write ignored", v, 16'hA5C3);
        wr(16'hFF06, 16'h0000); rd(16'hFF06, v); chk("R5 cleared", v, 0);
        chk("R7 irq dropped", irq, 0);
    endtask

    task automatic t_same_cycle;
        logic [DW-1:0] v;
        push(16'h1111); push(16'h2222);   // ready plus overrun
        @(negedge clk);
        bus_addr = 16'hFF06; bus_wdata = 16'h0000; bus_we = 1'b1;
        in_data = 16'h3333; in_valid = 1'b1;
        @(negedge clk); bus_we = 1'b0; in_valid = 1'b0;
        rd(16'hFF00, v); chk("R6 new word", v, 16'h3333);
        rd(16'hFF06, v); chk("R6 flags", v, 16'h0001);
        chk("R6 irq", irq, 1);
        wr(16'hFF06, 16'h0000);
    endtask

    task automatic t_output;
        logic [DW-1:0] v;
        int n;
        strobes = 0;
        wr(16'hFF02, 16'hC0DE);
        wr(16'hFF08, 16'h0001);
        rd(16'hFF08, v); chk("R9 done not yet", v, 16'h0001);
        n = 0;
        while (v[1] !== 1'b1 && n < LAT + 3) begin
            rd(16'hFF08, v); n++;
        end
        chk("R9 done", v, 16'h0003);
        chk("R8 one strobe", strobes, 1);
        chk("R8 strobe data", strobe_word, 16'hC0DE);
    endtask

    task automatic t_busy_and_clear;
        logic [DW-1:0] v;
        strobes = 0;
        wr(16'hFF08, 16'h0000);
        rd(16'hFF08, v); chk("R11 cleared", v, 0);
        wr(16'hFF08, 16'h0001);
        wr(16'hFF08, 16'h0001);   // repeated while busy
        repeat (LAT + 6) @(negedge clk);
        chk("R10 no second strobe", strobes, 1);
        rd(16'hFF08, v); chk("R9 done after busy", v, 16'h0003);
        wr(16'hFF08, 16'h0000);
        rd(16'hFF08, v); chk("R11 cleared again", v, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_map();
        t_input();
        t_overrun();
        t_clear();
        t_same_cycle();
        t_output();
        t_busy_and_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule